// File: doc/BRIEF.md
# Bit-Masked GPIO Register Bank

This block is the register front end of a 32-pin general-purpose I/O port. It holds the pin output values, the pin directions and seven per-pin configuration words, which go to the separate interrupt and debounce blocks. It also returns the pad input levels after a two-flop synchronizer. Software reaches it over a simple memory-mapped bus. The bus has a select, a write strobe, a byte address, 32-bit write data and a combinational read path.

Each 32-pin logical register is split into two 16-bit halves that sit in consecutive words. On a write, the upper 16 bits of the bus data act as per-bit update enables for the lower 16 bits. Software can therefore set or clear any single pin in one bus write, with no read-modify-write and no lock. The synchronized input word and a constant version word are read-only. Addresses that belong to the neighbouring interrupt-status and divider logic are not decoded in this bank, so they read as zero here.

Top module: `gpio_mask_bank`

## Requirements
- R1: While reset is asserted and after it is released, the pad output, the output enable and all seven configuration outputs are 0.
- R2: A write updates register bit n (n = 0..15 of the addressed half) to data bit n only when data bit n+16 is 1. Every bit whose enable is 0 keeps its value.
- R3: Register k occupies byte address 8*k (pins 0–15) and 8*k+4 (pins 16–31). A write to one half never changes the other half.
- R4: A read of either half of a writable register returns that half's 16 bits in rdata[15:0], with rdata[31:16] = 0.
- R5: The register at 0x00 drives `gpio_out_o`. The register at 0x08 drives `gpio_oe_o`, where 1 makes the pin an output and 0 makes it an input.
- R6: The registers at 0x10, 0x18, 0x20, 0x28, 0x30, 0x38 and 0x40 drive, in that order, interrupt enable, interrupt mask, trigger type, polarity, both-edge select, debounce enable and debounce-divider enable.
- R7: A read at 0x70 returns all 32 pad inputs in one word, after two clock edges of synchronization. A pad change made between edges shows on the second rising edge that follows, and `pad_sync_o` carries the same value.
- R8: A read at 0x78 returns the version constant 0x01000C2B.
- R9: Writes to 0x70, 0x78 or any undecoded address change no register. Reads from any address other than the writable registers, 0x70 and 0x78 return 0. The read data is 0 when no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data: [31:16] enables, [15:0] values |
| bus_rdata | output | 32 | Combinational read data |
| pad_in | input | 32 | Raw pad input levels |
| gpio_out_o | output | 32 | Pad output values |
| gpio_oe_o | output | 32 | Pad output enables |
| pad_sync_o | output | 32 | Synchronized pad inputs for interrupt logic |
| irq_en_o | output | 32 | Interrupt enable per pin |
| irq_mask_o | output | 32 | Interrupt mask per pin |
| irq_type_o | output | 32 | Trigger type per pin |
| irq_pol_o | output | 32 | Trigger polarity per pin |
| irq_both_o | output | 32 | Both-edge select per pin |
| db_en_o | output | 32 | Debounce enable per pin |
| db_div_en_o | output | 32 | Debounce-divider enable per pin |

## Verification
A corrupted storage bit appears on the matching pad or configuration output right after the write edge. It also appears in the readback of its half in the same cycle, so the bench compares both against a shadow model after every write. Enable masks that are sparse, full or empty show whether a mask bit leaks or a half is decoded wrongly: either fault shows up as a neighbour pin that moved. A synchronizer that is one stage short or long shows as an external-port value that changes one edge early or late, and the bench samples on both sides of the expected edge.

// File: rtl/gpio_mask_bank_pkg.sv
package gpio_mask_bank_pkg;
  localparam int HALF_W   = 16;
  localparam int PINS     = 2 * HALF_W;
  localparam int CFG_REGS = 7;              // interrupt and debounce configuration words
  localparam int RW_REGS  = 2 + CFG_REGS;   // data, direction, then configuration
  localparam int EXT_SLOT = 14;             // 0x70
  localparam int VER_SLOT = 15;             // 0x78
  localparam logic [31:0] VERSION_WORD = 32'h0100_0C2B;
endpackage

// File: rtl/gpio_mask_half.sv
module gpio_mask_half #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] bit_en,
  input  logic [W-1:0] bit_val,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt = (q & ~bit_en) | (bit_val & bit_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R2: unmasked bits take the data, masked bits hold
  assert_masked_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & $past(bit_en)) == ($past(bit_val) & $past(bit_en))));
  assert_masked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(q)) & ~$past(bit_en)) == '0));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_mask_bank_pkg::*;
#(
  parameter int          ADDR_W  = 7,
  parameter logic [31:0] VERSION = VERSION_WORD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   gpio_out_o,
  output logic [PINS-1:0]   gpio_oe_o,
  output logic [PINS-1:0]   pad_sync_o,
  output logic [PINS-1:0]   irq_en_o,
  output logic [PINS-1:0]   irq_mask_o,
  output logic [PINS-1:0]   irq_type_o,
  output logic [PINS-1:0]   irq_pol_o,
  output logic [PINS-1:0]   irq_both_o,
  output logic [PINS-1:0]   db_en_o,
  output logic [PINS-1:0]   db_div_en_o
);
  localparam int SLOT_W = ADDR_W - 3;
  localparam int HALVES = 2 * RW_REGS;

  logic [SLOT_W-1:0] slot;
  logic              upper;
  logic              wr_any;
  logic [HALF_W-1:0] half_q [HALVES];
  logic [PINS-1:0]   reg_word [RW_REGS];
  logic [PINS-1:0]   sync_q;

  assign slot   = bus_addr[ADDR_W-1:3];
  assign upper  = bus_addr[2];
  assign wr_any = bus_sel && bus_wr && (int'(slot) < RW_REGS);

  for (genvar k = 0; k < RW_REGS; k++) begin : g_reg
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic hit;
      assign hit = wr_any && (int'(slot) == k) && (upper == h[0]);
      gpio_mask_half #(.W(HALF_W)) u_half (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hit),
        .bit_en  (bus_wdata[2*HALF_W-1:HALF_W]),
        .bit_val (bus_wdata[HALF_W-1:0]),
        .q       (half_q[2*k+h])
      );
    end
    assign reg_word[k] = {half_q[2*k+1], half_q[2*k]};
  end

  gpio_in_sync #(.W(PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (sync_q)
  );

  assign gpio_out_o  = reg_word[0];
  assign gpio_oe_o   = reg_word[1];
  assign irq_en_o    = reg_word[2];
  assign irq_mask_o  = reg_word[3];
  assign irq_type_o  = reg_word[4];
  assign irq_pol_o   = reg_word[5];
  assign irq_both_o  = reg_word[6];
  assign db_en_o     = reg_word[7];
  assign db_div_en_o = reg_word[8];
  assign pad_sync_o  = sync_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (int'(slot) < RW_REGS)
        bus_rdata = {{(32-HALF_W){1'b0}}, half_q[2*int'(slot) + int'(upper)]};
      else if (int'(slot) == EXT_SLOT && !upper)
        bus_rdata = sync_q;
      else if (int'(slot) == VER_SLOT && !upper)
        bus_rdata = VERSION;
    end
  end

  // R9: writes outside the writable registers leave all storage unchanged
  assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && int'(slot) >= RW_REGS) |=>
      ($stable(gpio_out_o) && $stable(gpio_oe_o) && $stable(irq_en_o) && $stable(db_div_en_o)));
  // R3: a write to the upper half of output data keeps pins 0..15
  assert_half_isolation_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && slot == '0 && upper) |=> $stable(gpio_out_o[HALF_W-1:0]));
  // R4: readback of a writable register has a zero upper half
  assert_read_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && int'(slot) < RW_REGS) |-> (bus_rdata[31:HALF_W] == '0));
  // R8: version word
  assert_version_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && int'(slot) == VER_SLOT && !upper) |-> (bus_rdata == VERSION));
  // R7: external port read matches the synchronizer output port
  assert_ext_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && int'(slot) == EXT_SLOT && !upper) |-> (bus_rdata == pad_sync_o));
endmodule

// File: tb/tb_gpio_mask_bank.sv
module tb_gpio_mask_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pad_in;
  logic [31:0] gpio_out_o, gpio_oe_o, pad_sync_o, irq_en_o, irq_mask_o, irq_type_o,
               irq_pol_o, irq_both_o, db_en_o, db_div_en_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [9];

  always #2 clk = ~clk;

  gpio_mask_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .gpio_out_o(gpio_out_o), .gpio_oe_o(gpio_oe_o), .pad_sync_o(pad_sync_o),
    .irq_en_o(irq_en_o), .irq_mask_o(irq_mask_o), .irq_type_o(irq_type_o),
    .irq_pol_o(irq_pol_o), .irq_both_o(irq_both_o), .db_en_o(db_en_o),
    .db_div_en_o(db_div_en_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_out(input int k);
    case (k)
      0: return gpio_out_o;   1: return gpio_oe_o;   2: return irq_en_o;
      3: return irq_mask_o;   4: return irq_type_o;  5: return irq_pol_o;
      6: return irq_both_o;   7: return db_en_o;     default: return db_div_en_o;
    endcase
  endfunction

  task automatic bwrite(input logic [6:0] a, input logic [15:0] en, input logic [15:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = {en, v};
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic mwrite(input int k, input int h, input logic [15:0] en, input logic [15:0] v);
    logic [15:0] cur;
    bwrite(7'(8*k + 4*h), en, v);
    cur = h ? model[k][31:16] : model[k][15:0];
    cur = (cur & ~en) | (v & en);
    if (h) model[k][31:16] = cur; else model[k][15:0] = cur;
  endtask

  task automatic verify_all(input string req);
    logic [31:0] d;
    for (int k = 0; k < 9; k++) begin
      chk(req, cfg_out(k), model[k]);
      bread(7'(8*k), d);     chk(req, d, {16'h0, model[k][15:0]});
      bread(7'(8*k + 4), d); chk(req, d, {16'h0, model[k][31:16]});
    end
  endtask

  task automatic t_reset;
    for (int k = 0; k < 9; k++) model[k] = '0;
    verify_all("R1 reset");
  endtask

  task automatic t_masked;
    mwrite(0, 0, 16'hFFFF, 16'hA5C3);
    chk("R2 full-enable write", gpio_out_o, 32'h0000_A5C3);
    mwrite(0, 0, 16'h0000, 16'h0000);
    chk("R2 empty enable ignored", gpio_out_o, 32'h0000_A5C3);
    mwrite(0, 0, 16'h0101, 16'h0100);
    chk("R2 single-bit set/clear", gpio_out_o, model[0]);
    verify_all("R2 masked");
  endtask

  task automatic t_halves;
    mwrite(0, 1, 16'hFFFF, 16'h1234);
    chk("R3 upper half keeps lower", gpio_out_o[15:0], model[0][15:0]);
    chk("R3 upper half value", gpio_out_o[31:16], 16'h1234);
    mwrite(1, 1, 16'h8000, 16'hFFFF);
    chk("R5 direction pin31 output", gpio_oe_o, 32'h8000_0000);
    mwrite(1, 0, 16'h0001, 16'h0001);
    chk("R5 direction pin0 output", gpio_oe_o, 32'h8000_0001);
    verify_all("R4 readback");
  endtask

  task automatic t_cfg;
    for (int k = 2; k < 9; k++) begin
      mwrite(k, k % 2, 16'hFFFF, 16'(k * 16'h1111));
      mwrite(k, 1 - (k % 2), 16'h00FF, 16'h5A5A);
    end
    verify_all("R6 config");
  endtask

  task automatic t_ext;
    logic [31:0] d;
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    chk("R7 not yet after one edge", pad_sync_o, 32'h0);
    @(posedge clk); #1;
    chk("R7 after two edges", pad_sync_o, 32'hDEAD_BEEF);
    bread(7'h70, d); chk("R7 ext read", d, 32'hDEAD_BEEF);
    @(negedge clk); pad_in = 32'h0F0F_0001;
    repeat (2) @(posedge clk);
    bread(7'h70, d); chk("R7 ext read second", d, 32'h0F0F_0001);
    bread(7'h74, d); chk("R9 0x74 reads zero", d, 32'h0);
  endtask

  task automatic t_version;
    logic [31:0] d;
    bread(7'h78, d); chk("R8 version", d, 32'h0100_0C2B);
    bread(7'h7C, d); chk("R9 0x7C reads zero", d, 32'h0);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    bwrite(7'h70, 16'hFFFF, 16'hFFFF);
    bwrite(7'h78, 16'hFFFF, 16'h0000);
    bwrite(7'h48, 16'hFFFF, 16'hFFFF);
    bwrite(7'h60, 16'hFFFF, 16'hFFFF);
    verify_all("R9 ignored writes");
    bread(7'h78, d); chk("R9 version unchanged", d, 32'h0100_0C2B);
    bread(7'h48, d); chk("R9 unmapped 0x48", d, 32'h0);
    bread(7'h58, d); chk("R9 unmapped 0x58", d, 32'h0);
    chk("R9 idle rdata zero", bus_rdata, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    #1;
    chk("R1 during reset out", gpio_out_o, 32'h0);
    chk("R1 during reset oe", gpio_oe_o, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masked();
    t_halves();
    t_cfg();
    t_ext();
    t_version();
    t_readonly();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule